// File: doc/BRIEF.md
# Register Rename Map with Physical Register Free List

This block translates architectural register names into physical register names. Each instruction offered to it has its two source names looked up in the current map. If the instruction writes a register, it takes a fresh physical register from the head of a first-in first-out free list, and its destination entry is rewritten to point at that register. The map entry that was replaced leaves on `phys_old`. Downstream logic holds that value and hands it back through the release port once the last reader of the old value has finished. From then on, dependency tracking, bypass and scoreboarding downstream all work on physical names only. Reusing an architectural name therefore creates no false ordering.

Translation is combinational within the offering cycle. The map and free list update on the next rising edge. When the free list is empty, an instruction with a destination is held off through `ren_stall`. A release can be accepted in the same cycle as an allocation.

The free list carries a small occupancy state machine with three states:
- `FL_FULL`: every spare register is free.
- `FL_PARTIAL`: some but not all spare registers are free.
- `FL_EMPTY`: no register is free.

Its transitions are:
- FULL→PARTIAL when an allocation is not matched by a release.
- PARTIAL→EMPTY when the count reaches zero.
- PARTIAL→FULL when the count reaches the spare total.
- EMPTY→PARTIAL on any release.

Every other combination keeps the current state.

Top module: `rename_unit`

## Requirements
- R1: After reset, architectural register i maps to physical register i for every i in 0..7, and `free_count` reads 8.
- R2: `phys_src_a` and `phys_src_b` show, in the same cycle, the current mapping of `ren_src_a` and `ren_src_b`, with every earlier accepted allocation applied.
- R3: An accepted instruction with a destination (`ren_valid`=1, `ren_has_dst`=1, `ren_stall`=0) rewrites the map entry of `ren_dst` to `phys_dst` at the next rising edge, and `free_count` drops by one.
- R4: When an instruction reads and writes the same architectural name, its source lookups return the old mapping, and `phys_old` equals that old mapping.
- R5: Following reset, the first eight allocations hand out physical registers 8, 9, 10, …, 15 in that order.
- R6: A released physical register joins the tail of the free list and is handed out only after every register already in the list.
- R7: `ren_stall` is 1 exactly when `ren_valid`=1, `ren_has_dst`=1 and the free list is empty. A stalled instruction changes neither the map nor `free_count`.
- R8: An instruction with `ren_has_dst`=0 is never stalled, leaves the map unchanged and does not alter `free_count`.
- R9: A release and an allocation in the same cycle both take effect, and `free_count` stays the same.
- R10: `free_count` always equals the number of registers in the free list and never exceeds 8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ren_valid | input | 1 | An instruction is offered for renaming |
| ren_has_dst | input | 1 | The offered instruction writes a register |
| ren_src_a | input | 3 | First source architectural name |
| ren_src_b | input | 3 | Second source architectural name |
| ren_dst | input | 3 | Destination architectural name |
| rel_valid | input | 1 | Return a physical register to the free list |
| rel_preg | input | 4 | Physical register being returned |
| ren_stall | output | 1 | Offered instruction must wait (free list empty) |
| ren_fire | output | 1 | Offered instruction is accepted this cycle |
| phys_src_a | output | 4 | Physical name of the first source |
| phys_src_b | output | 4 | Physical name of the second source |
| phys_dst | output | 4 | Physical register allocated to the destination |
| phys_old | output | 4 | Superseded mapping of the destination |
| free_count | output | 4 | Number of free physical registers |

## Verification
These outputs are combinational in the cycle an instruction is offered:
- the two source names and the allocated and superseded registers;
- `ren_stall` and `ren_fire`.

The map rewrite and the change in `free_count` appear one rising edge later. The bench drives stimulus on the falling edge and samples the combinational results 1 ns afterwards. Only after the following rising edge does it apply the same instruction's effect to its own map and free-list queue. As a result, every lookup in the next offering sees exactly one edge's worth of update.

The sweep runs through the following cases:
- all eight names after reset;
- the reset allocation order;
- the empty-list stall and the no-destination case;
- a simultaneous release and allocation;
- a long pseudo-random mix in which releases return only previously superseded registers.

// File: rtl/ren_pkg.sv
package ren_pkg;

    // Occupancy state of the physical register free list
    typedef enum logic [1:0] {
        FL_FULL    = 2'd0,
        FL_PARTIAL = 2'd1,
        FL_EMPTY   = 2'd2
    } fl_state_e;

endpackage

// File: rtl/rename_map.sv
module rename_map #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int AW = $clog2(NUM_ARCH),
    localparam int PW = $clog2(NUM_PHYS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    input  logic [AW-1:0] rd_d_idx,
    output logic [PW-1:0] rd_a,
    output logic [PW-1:0] rd_b,
    output logic [PW-1:0] rd_d,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_idx,
    input  logic [PW-1:0] wr_preg
);

    logic [NUM_ARCH-1:0][PW-1:0] map_q;

    // Reads see the table as it stood before this cycle's write
    assign rd_a = map_q[rd_a_idx];
    assign rd_b = map_q[rd_b_idx];
    assign rd_d = map_q[rd_d_idx];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_ARCH; i++) begin
                map_q[i] <= PW'(i);
            end
        end else if (wr_en) begin
            map_q[wr_idx] <= wr_preg;
        end
    end

    AST_MAP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !wr_en) |=> $stable(map_q)); // R8

    AST_MAP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && wr_en) |=> (map_q[$past(wr_idx)] == $past(wr_preg))); // R3

endmodule

// File: rtl/rename_freelist.sv
module rename_freelist
    import ren_pkg::*;
#(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int PW    = $clog2(NUM_PHYS),
    localparam int DEPTH = NUM_PHYS - NUM_ARCH,
    localparam int PTRW  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CNTW  = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pop,
    input  logic            push,
    input  logic [PW-1:0]   push_preg,
    output logic [PW-1:0]   head_preg,
    output logic            empty,
    output logic [CNTW-1:0] count
);

    logic [DEPTH-1:0][PW-1:0] slot_q;
    logic [PTRW-1:0]          head_q, tail_q;
    logic [CNTW-1:0]          cnt_q, cnt_nxt;
    logic                     do_pop, do_push, full;
    fl_state_e                state_q, state_nxt;

    function automatic logic [PTRW-1:0] wrap_inc(input logic [PTRW-1:0] p);
        return (p == PTRW'(DEPTH - 1)) ? '0 : p + PTRW'(1);
    endfunction

    assign do_pop  = pop && !empty;
    assign do_push = push && (!full || do_pop);
    assign head_preg = slot_q[head_q];
    assign count     = cnt_q;

    always_comb begin
        cnt_nxt = cnt_q;
        if (do_pop && !do_push) cnt_nxt = cnt_q - CNTW'(1);
        if (do_push && !do_pop) cnt_nxt = cnt_q + CNTW'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < DEPTH; k++) begin
                slot_q[k] <= PW'(NUM_ARCH + k);
            end
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= CNTW'(DEPTH);
        end else begin
            if (do_pop) head_q <= wrap_inc(head_q);
            if (do_push) begin
                slot_q[tail_q] <= push_preg;
                tail_q         <= wrap_inc(tail_q);
            end
            cnt_q <= cnt_nxt;
        end
    end

    // Occupancy state machine: state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= FL_FULL;
        else        state_q <= state_nxt;
    end

    // Occupancy state machine: next state
    always_comb begin
        state_nxt = state_q;
        unique case (state_q)
            FL_FULL:    if (do_pop && !do_push) state_nxt = FL_PARTIAL;
            FL_PARTIAL: begin
                if (cnt_nxt == '0)                state_nxt = FL_EMPTY;
                else if (cnt_nxt == CNTW'(DEPTH)) state_nxt = FL_FULL;
            end
            FL_EMPTY:   if (do_push) state_nxt = (DEPTH == 1) ? FL_FULL : FL_PARTIAL;
            default:    state_nxt = FL_FULL;
        endcase
    end

    // Occupancy state machine: outputs
    always_comb begin
        empty = (state_q == FL_EMPTY);
        full  = (state_q == FL_FULL);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        !(push && full && !pop)); // R10

    AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNTW'(DEPTH)); // R10

    AST_EMPTY_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == FL_EMPTY) == (cnt_q == '0)); // R7

    AST_POP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && do_pop && !push) |=> (cnt_q == $past(cnt_q) - CNTW'(1))); // R3

    AST_BOTH_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && do_pop && push) |=> $stable(cnt_q)); // R9

endmodule

// File: rtl/rename_unit.sv
module rename_unit #(
    parameter int NUM_ARCH = 8,
    parameter int NUM_PHYS = 16,
    localparam int AW   = $clog2(NUM_ARCH),
    localparam int PW   = $clog2(NUM_PHYS),
    localparam int CNTW = $clog2(NUM_PHYS - NUM_ARCH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            ren_valid,
    input  logic            ren_has_dst,
    input  logic [AW-1:0]   ren_src_a,
    input  logic [AW-1:0]   ren_src_b,
    input  logic [AW-1:0]   ren_dst,
    input  logic            rel_valid,
    input  logic [PW-1:0]   rel_preg,
    output logic            ren_stall,
    output logic            ren_fire,
    output logic [PW-1:0]   phys_src_a,
    output logic [PW-1:0]   phys_src_b,
    output logic [PW-1:0]   phys_dst,
    output logic [PW-1:0]   phys_old,
    output logic [CNTW-1:0] free_count
);

    logic fl_empty;
    logic alloc;

    assign ren_stall = ren_valid && ren_has_dst && fl_empty;
    assign ren_fire  = ren_valid && !ren_stall;
    assign alloc     = ren_fire && ren_has_dst;

    rename_map #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_map (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_a_idx (ren_src_a),
        .rd_b_idx (ren_src_b),
        .rd_d_idx (ren_dst),
        .rd_a     (phys_src_a),
        .rd_b     (phys_src_b),
        .rd_d     (phys_old),
        .wr_en    (alloc),
        .wr_idx   (ren_dst),
        .wr_preg  (phys_dst)
    );

    rename_freelist #(.NUM_ARCH(NUM_ARCH), .NUM_PHYS(NUM_PHYS)) u_free (
        .clk       (clk),
        .rst_n     (rst_n),
        .pop       (alloc),
        .push      (rel_valid),
        .push_preg (rel_preg),
        .head_preg (phys_dst),
        .empty     (fl_empty),
        .count     (free_count)
    );

    AST_STALL_ONLY_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ren_stall |-> (free_count == '0)); // R7

    AST_STALL_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && ren_stall && !rel_valid) |=> (free_count == '0)); // R7

    AST_NODST_NOSTALL: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_valid && !ren_has_dst) |-> ren_fire); // R8

    AST_NEW_NOT_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        ren_fire && ren_has_dst |-> (phys_dst != phys_old)); // R4

endmodule

// File: tb/tb_rename_unit.sv
module tb_rename_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ren_valid = 1'b0, ren_has_dst = 1'b0, rel_valid = 1'b0;
    logic [2:0] ren_src_a = '0, ren_src_b = '0, ren_dst = '0;
    logic [3:0] rel_preg = '0;
    logic       ren_stall, ren_fire;
    logic [3:0] phys_src_a, phys_src_b, phys_dst, phys_old, free_count;

    int checks = 0;
    int failures = 0;
    int mt[8];
    int fq[$];
    int pend[$];
    int lfsr = 32'h1ACE;
    bit done = 1'b0;

    always #4 clk = ~clk;

    rename_unit dut (
        .clk(clk), .rst_n(rst_n), .ren_valid(ren_valid), .ren_has_dst(ren_has_dst),
        .ren_src_a(ren_src_a), .ren_src_b(ren_src_b), .ren_dst(ren_dst),
        .rel_valid(rel_valid), .rel_preg(rel_preg), .ren_stall(ren_stall),
        .ren_fire(ren_fire), .phys_src_a(phys_src_a), .phys_src_b(phys_src_b),
        .phys_dst(phys_dst), .phys_old(phys_old), .free_count(free_count)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive on the falling edge, check combinational outputs 1 ns later,
    // then apply the instruction to the model after the rising edge.
    task automatic step(input bit v, input int sa, input int sb, input bit hd,
                        input int d, input bit rv, input int rp, input string tag);
        bit exp_stall, exp_alloc;
        int new_p;
        @(negedge clk);
        ren_valid = v; ren_src_a = 3'(sa); ren_src_b = 3'(sb);
        ren_has_dst = hd; ren_dst = 3'(d); rel_valid = rv; rel_preg = 4'(rp);
        #1;
        exp_stall = v && hd && (fq.size() == 0);
        exp_alloc = v && hd && !exp_stall;
        chk(phys_src_a == 4'(mt[sa]), {tag, " R2 src_a"}, phys_src_a, mt[sa]);
        chk(phys_src_b == 4'(mt[sb]), {tag, " R2 src_b"}, phys_src_b, mt[sb]);
        chk(ren_stall == exp_stall, {tag, " R7 stall"}, ren_stall, exp_stall);
        chk(ren_fire == (v && !exp_stall), {tag, " R8 fire"}, ren_fire, v && !exp_stall);
        chk(free_count == 4'(fq.size()), {tag, " R10 count"}, free_count, fq.size());
        new_p = 0;
        if (exp_alloc) begin
            new_p = fq[0];
            chk(phys_dst == 4'(new_p), {tag, " R6 fifo order"}, phys_dst, new_p);
            chk(phys_old == 4'(mt[d]), {tag, " R4 old map"}, phys_old, mt[d]);
        end
        @(posedge clk);
        if (exp_alloc) begin
            void'(fq.pop_front());
            pend.push_back(mt[d]);
            mt[d] = new_p;
        end
        if (rv) fq.push_back(rp);
    endtask

    task automatic idle_check(input string tag, input int exp_cnt);
        @(negedge clk);
        ren_valid = 1'b0; rel_valid = 1'b0;
        #1;
        chk(free_count == 4'(exp_cnt), tag, free_count, exp_cnt);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) mt[i] = i;
        for (int k = 8; k < 16; k++) fq.push_back(k);
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: reset map and count, all names swept
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ren_src_a = 3'(i); ren_src_b = 3'(7 - i);
            #1;
            chk(phys_src_a == 4'(i), "R1 reset map a", phys_src_a, i);
            chk(phys_src_b == 4'(7 - i), "R1 reset map b", phys_src_b, 7 - i);
        end
        chk(free_count == 4'd8, "R1 reset count", free_count, 8);

        // R5 / R4: eight allocations, each reading and writing the same name
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ren_valid = 1'b1; ren_has_dst = 1'b1; ren_dst = 3'(i);
            ren_src_a = 3'(i); ren_src_b = 3'(i); rel_valid = 1'b0;
            #1;
            chk(phys_dst == 4'(8 + i), "R5 reset alloc order", phys_dst, 8 + i);
            chk(phys_src_a == 4'(i), "R4 same-name src old", phys_src_a, i);
            chk(phys_old == 4'(i), "R4 same-name old map", phys_old, i);
            @(posedge clk);
            void'(fq.pop_front());
            pend.push_back(i);
            mt[i] = 8 + i;
        end
        // R3: new mappings visible, count drained
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            ren_valid = 1'b0; ren_src_a = 3'(i);
            #1;
            chk(phys_src_a == 4'(8 + i), "R3 map updated", phys_src_a, 8 + i);
        end
        chk(free_count == 4'd0, "R3 count after eight", free_count, 0);

        // R7: stall with empty list, nothing changes
        step(1, 2, 3, 1, 5, 0, 0, "R7 empty");
        chk(ren_stall == 1'b1, "R7 stall seen", ren_stall, 1);
        idle_check("R7 count held", 0);
        step(1, 5, 5, 0, 5, 0, 0, "R7 map held");
        // R8: no destination, never stalled, count unchanged
        step(1, 1, 6, 0, 1, 0, 0, "R8 nodst");
        idle_check("R8 count unchanged", 0);

        // R6: release two, they come back in order
        step(0, 0, 0, 0, 0, 1, pend.pop_front(), "R6 rel0");
        step(0, 0, 0, 0, 0, 1, pend.pop_front(), "R6 rel1");
        idle_check("R6 count two", 2);
        step(1, 3, 3, 1, 3, 0, 0, "R6 alloc first");
        // R9: release and allocation together
        step(1, 4, 0, 1, 4, 1, pend.pop_front(), "R9 both");
        idle_check("R9 count same", 1);

        // Mixed pseudo-random sweep, legal releases only
        for (int n = 0; n < 3000; n++) begin
            bit v, hd, rv;
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hB400 : 0);
            v  = lfsr[0];
            hd = lfsr[1] | lfsr[2];
            rv = lfsr[3] && (pend.size() > 0) && (fq.size() < 8);
            step(v, (lfsr >> 4) & 7, (lfsr >> 7) & 7, hd, (lfsr >> 10) & 7,
                 rv, rv ? pend.pop_front() : 0, "R2 sweep");
        end

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule